// File: doc/BRIEF.md
# RISC Integer Execute Unit

This block is the combinational execute stage of a 32-bit load/store integer core. Each cycle the decode stage presents an operation code, two register operands, a 16-bit immediate field and a 5-bit shift count; within the same cycle the block returns a 32-bit result for write-back and a flag that says whether the two register operands match. Branch logic uses the flag to resolve branch-if-equal and branch-if-not-equal without taking up an arithmetic slot.

The immediate field is widened inside the block. How it is widened depends on the operation: arithmetic and compare forms replicate the sign bit, the bitwise forms pad with zeros, and the load-upper form moves the field into the top half of the word. Compares return 0 or 1 in the result word rather than setting condition codes. Add and subtract wrap modulo 2^32 and give no overflow indication. The block has no registers and no state machine: a decoder picks an immediate mode, an operand source and a function, and three small datapath units produce the value.

Top module: `rx_exec_unit`

## Requirements
- R1: `op_sel` encodes the operations as 0 add, 1 subtract, 2 and, 3 or, 4 nor, 5 set-less-than, 6 shift-left, 7 shift-right, 8 add-immediate, 9 and-immediate, 10 or-immediate, 11 set-less-than-immediate, 12 load-upper. Add and subtract use `src_a` and `src_b`, wrap modulo 2^32, and give no overflow indication.
- R2: Add-immediate adds `imm_val` sign-extended from bit 15 to `src_a`, so a negative field subtracts.
- R3: And-immediate and or-immediate combine `src_a` with `imm_val` zero-extended, so bits 31..16 of the result equal `src_a[31:16]` for or-immediate and are 0 for and-immediate.
- R4: Load-upper gives `result[31:16] = imm_val` and `result[15:0] = 0`, whatever the value of `src_a`.
- R5: Set-less-than returns 1 when `src_a` is less than `src_b` as a signed two's-complement number and 0 otherwise (0x80000000 is less than 0). The immediate form compares `src_a` with the sign-extended `imm_val`. Bits 31..1 of the result are always 0.
- R6: And, or and nor combine `src_a` and `src_b` bitwise. Nor returns the inverse of their OR.
- R7: Shift-left and shift-right move `src_a` by `shamt` places and fill the vacated bits with zeros. A shift count of 0 passes `src_a` through unchanged.
- R8: `eq_flag` is 1 exactly when `src_a` equals `src_b`. This holds for every operation code.
- R9: Load-upper with field H, then or-immediate with field L applied to that result, gives {H, L} (for example 0xFAFA then 0xFBFB gives 0xFAFAFBFB).
- R10: Operation codes 13 to 15 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (encoding in R1) |
| src_a | input | 32 | First register operand; also the source for shifts |
| src_b | input | 32 | Second register operand |
| imm_val | input | 16 | Immediate field from the instruction |
| shamt | input | 5 | Constant shift count |
| result | output | 32 | Value to write back |
| eq_flag | output | 1 | Operands equal, used for branch decisions |

## Verification
Directed operands are chosen so that a wrong immediate rule shows up. An immediate with bit 15 set gives different results under sign and zero extension, so the add-immediate, and-immediate, or-immediate and set-less-than-immediate cases show whether each operation uses the right rule. Signed compares are tried with the most negative value against zero, and with operands of the same sign, to expose an unsigned compare. Shifts by 0, 16 and 31 on an asymmetric bit pattern check the fill direction and any off-by-one in the count. The load-upper then or-immediate pair is run on a dirty `src_a` to show that no leftover low bits survive. `eq_flag` is checked under an unrelated operation code, with operands that are equal and with operands that differ only in their top bit.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_ADDI = 4'd8,
        OP_ANDI = 4'd9,
        OP_ORI  = 4'd10,
        OP_SLTI = 4'd11,
        OP_LUI  = 4'd12
    } rx_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } rx_ext_e;

    typedef enum logic [2:0] {
        FN_ADD  = 3'd0,
        FN_SUB  = 3'd1,
        FN_AND  = 3'd2,
        FN_OR   = 3'd3,
        FN_NOR  = 3'd4,
        FN_SLT  = 3'd5,
        FN_PASS = 3'd6,
        FN_ZERO = 3'd7
    } rx_fn_e;

endpackage

// File: rtl/rx_imm_ext.sv
module rx_imm_ext #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned IMMW = 16
) (
    input  rx_pkg::rx_ext_e   mode,
    input  logic [IMMW-1:0]   imm,
    output logic [XLEN-1:0]   ext
);
    localparam int unsigned PADW = XLEN - IMMW;

    always_comb begin
        ext = '0;
        unique case (mode)
            rx_pkg::EXT_SIGN:  ext = {{PADW{imm[IMMW-1]}}, imm};
            rx_pkg::EXT_ZERO:  ext = {{PADW{1'b0}}, imm};
            rx_pkg::EXT_UPPER: ext[XLEN-1 -: IMMW] = imm;
            default:           ext = '0;
        endcase
    end
endmodule

// File: rtl/rx_alu_core.sv
module rx_alu_core #(
    parameter int unsigned XLEN = 32
) (
    input  rx_pkg::rx_fn_e    fn,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    output logic [XLEN-1:0]   res
);
    logic lt_signed;

    assign lt_signed = $signed(opa) < $signed(opb);

    always_comb begin
        res = '0;
        unique case (fn)
            rx_pkg::FN_ADD:  res = opa + opb;
            rx_pkg::FN_SUB:  res = opa - opb;
            rx_pkg::FN_AND:  res = opa & opb;
            rx_pkg::FN_OR:   res = opa | opb;
            rx_pkg::FN_NOR:  res = ~(opa | opb);
            rx_pkg::FN_SLT:  res = {{(XLEN-1){1'b0}}, lt_signed};
            rx_pkg::FN_PASS: res = opb;
            rx_pkg::FN_ZERO: res = '0;
            default:         res = '0;
        endcase
    end
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned SHW  = $clog2(XLEN)
) (
    input  logic              go_left,
    input  logic [XLEN-1:0]   din,
    input  logic [SHW-1:0]    amt,
    output logic [XLEN-1:0]   dout
);
    always_comb begin
        if (go_left) dout = din << amt;
        else         dout = din >> amt;
    end
endmodule

// File: rtl/rx_exec_unit.sv
module rx_exec_unit #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned IMMW = 16,
    parameter int unsigned OPW  = 4,
    localparam int unsigned SHW = $clog2(XLEN)
) (
    input  logic [OPW-1:0]  op_sel,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [IMMW-1:0] imm_val,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] result,
    output logic            eq_flag
);
    import rx_pkg::*;

    rx_fn_e          fn_sel;
    rx_ext_e         ext_sel;
    logic            use_imm;
    logic            use_shift;
    logic            shift_left;
    logic [XLEN-1:0] imm_wide;
    logic [XLEN-1:0] opb_mux;
    logic [XLEN-1:0] alu_res;
    logic [XLEN-1:0] sh_res;

    // Decode: operation code to datapath controls
    always_comb begin
        fn_sel     = FN_ZERO;
        ext_sel    = EXT_SIGN;
        use_imm    = 1'b0;
        use_shift  = 1'b0;
        shift_left = 1'b0;
        unique case (op_sel)
            OP_ADD:  fn_sel = FN_ADD;
            OP_SUB:  fn_sel = FN_SUB;
            OP_AND:  fn_sel = FN_AND;
            OP_OR:   fn_sel = FN_OR;
            OP_NOR:  fn_sel = FN_NOR;
            OP_SLT:  fn_sel = FN_SLT;
            OP_SLL:  begin use_shift = 1'b1; shift_left = 1'b1; end
            OP_SRL:  use_shift = 1'b1;
            OP_ADDI: begin fn_sel = FN_ADD; use_imm = 1'b1; ext_sel = EXT_SIGN; end
            OP_ANDI: begin fn_sel = FN_AND; use_imm = 1'b1; ext_sel = EXT_ZERO; end
            OP_ORI:  begin fn_sel = FN_OR;  use_imm = 1'b1; ext_sel = EXT_ZERO; end
            OP_SLTI: begin fn_sel = FN_SLT; use_imm = 1'b1; ext_sel = EXT_SIGN; end
            OP_LUI:  begin fn_sel = FN_PASS; use_imm = 1'b1; ext_sel = EXT_UPPER; end
            default: fn_sel = FN_ZERO;
        endcase
    end

    rx_imm_ext #(.XLEN(XLEN), .IMMW(IMMW)) u_ext (
        .mode (ext_sel),
        .imm  (imm_val),
        .ext  (imm_wide)
    );

    assign opb_mux = use_imm ? imm_wide : src_b;

    rx_alu_core #(.XLEN(XLEN)) u_alu (
        .fn  (fn_sel),
        .opa (src_a),
        .opb (opb_mux),
        .res (alu_res)
    );

    rx_shifter #(.XLEN(XLEN), .SHW(SHW)) u_shf (
        .go_left (shift_left),
        .din     (src_a),
        .amt     (shamt),
        .dout    (sh_res)
    );

    assign result  = use_shift ? sh_res : alu_res;
    assign eq_flag = (src_a == src_b);

endmodule

// File: rtl/rx_exec_unit_chk.sv
module rx_exec_unit_chk #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned IMMW = 16,
    parameter int unsigned OPW  = 4,
    localparam int unsigned SHW = $clog2(XLEN)
) (
    input logic [OPW-1:0]  op_sel,
    input logic [XLEN-1:0] src_a,
    input logic [XLEN-1:0] src_b,
    input logic [IMMW-1:0] imm_val,
    input logic [SHW-1:0]  shamt,
    input logic [XLEN-1:0] result,
    input logic            eq_flag
);
    localparam int unsigned LOW = XLEN - IMMW;

    logic [XLEN-1:0] low_mask;
    logic [XLEN-1:0] high_keep;

    assign low_mask  = (XLEN'(1) << shamt) - XLEN'(1);
    assign high_keep = {XLEN{1'b1}} >> shamt;

    always_comb begin
        if (op_sel == rx_pkg::OP_LUI) begin
            p_lui_shape_r4: assert (result[XLEN-1 -: IMMW] == imm_val && result[LOW-1:0] == '0)
                else $error("load-upper shape wrong");
        end
        if (op_sel == rx_pkg::OP_SLT || op_sel == rx_pkg::OP_SLTI) begin
            p_slt_bool_r5: assert (result[XLEN-1:1] == '0)
                else $error("compare result not 0/1");
        end
        if (op_sel == rx_pkg::OP_ANDI) begin
            p_andi_upper_r3: assert (result[XLEN-1:IMMW] == '0)
                else $error("and-immediate upper bits set");
        end
        if (op_sel == rx_pkg::OP_ORI) begin
            p_ori_upper_r3: assert (result[XLEN-1:IMMW] == src_a[XLEN-1:IMMW])
                else $error("or-immediate upper bits altered");
        end
        if (op_sel == rx_pkg::OP_NOR) begin
            p_nor_disjoint_r6: assert ((result & (src_a | src_b)) == '0 && (result | src_a | src_b) == '1)
                else $error("nor not inverse of or");
        end
        if (op_sel == rx_pkg::OP_SLL) begin
            p_sll_fill_r7: assert ((result & low_mask) == '0)
                else $error("shift-left fill not zero");
        end
        if (op_sel == rx_pkg::OP_SRL) begin
            p_srl_fill_r7: assert ((result & ~high_keep) == '0)
                else $error("shift-right fill not zero");
        end
        if (op_sel == rx_pkg::OP_SUB) begin
            p_eq_sub_r8: assert (eq_flag == (result == '0))
                else $error("equal flag disagrees with difference");
        end
        if (op_sel > OPW'(12)) begin
            p_unused_zero_r10: assert (result == '0)
                else $error("unused code produced a value");
        end
    end
endmodule

bind rx_exec_unit rx_exec_unit_chk #(.XLEN(XLEN), .IMMW(IMMW), .OPW(OPW)) chk_i (
    .op_sel  (op_sel),
    .src_a   (src_a),
    .src_b   (src_b),
    .imm_val (imm_val),
    .shamt   (shamt),
    .result  (result),
    .eq_flag (eq_flag)
);

// File: tb/rx_exec_unit_tb_top.sv
module rx_exec_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm_val = '0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        eq_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rx_exec_unit dut_i (
        .op_sel  (op_sel),
        .src_a   (src_a),
        .src_b   (src_b),
        .imm_val (imm_val),
        .shamt   (shamt),
        .result  (result),
        .eq_flag (eq_flag)
    );

    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] imm, input logic [4:0] sh);
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; imm_val = imm; shamt = sh;
        #1;
    endtask

    task automatic chk_res(input string req, input logic [31:0] exp);
        n_tests++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s: result actual=%h expected=%h", req, result, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic exp);
        n_tests++;
        if (eq_flag !== exp) begin
            n_fail++;
            $display("FAIL %s: eq_flag actual=%b expected=%b", req, eq_flag, exp);
        end
    endtask

    task automatic t_reset_state;
        drive(4'd0, 32'h0, 32'h0, 16'h0, 5'd0);
        chk_res("R1 idle", 32'h0);
        chk_eq("R8 idle", 1'b1);
    endtask

    task automatic t_add_sub;   // R1
        drive(4'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 5'd0);
        chk_res("R1 add wrap", 32'h0);
        drive(4'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 5'd0);
        chk_res("R1 add no trap", 32'h8000_0000);
        drive(4'd1, 32'h0000_0005, 32'h0000_0007, 16'h0, 5'd0);
        chk_res("R1 sub borrow", 32'hFFFF_FFFE);
    endtask

    task automatic t_addi;      // R2
        drive(4'd8, 32'h0000_1000, 32'h0, 16'hFFFC, 5'd0);
        chk_res("R2 addi negative", 32'h0000_0FFC);
        drive(4'd8, 32'h0000_0010, 32'h0, 16'h0064, 5'd0);
        chk_res("R2 addi positive", 32'h0000_0074);
    endtask

    task automatic t_logic_imm; // R3
        drive(4'd9, 32'hFFFF_FFFF, 32'h0, 16'h8421, 5'd0);
        chk_res("R3 andi zero-ext", 32'h0000_8421);
        drive(4'd10, 32'h1234_0000, 32'h0, 16'hF00F, 5'd0);
        chk_res("R3 ori zero-ext", 32'h1234_F00F);
    endtask

    task automatic t_lui;       // R4
        drive(4'd12, 32'hDEAD_BEEF, 32'h0, 16'h00FF, 5'd0);
        chk_res("R4 lui", 32'h00FF_0000);
    endtask

    task automatic t_slt;       // R5
        drive(4'd5, 32'h8000_0000, 32'h0, 16'h0, 5'd0);
        chk_res("R5 slt min<0", 32'h1);
        drive(4'd5, 32'h0000_0003, 32'hFFFF_FFFF, 16'h0, 5'd0);
        chk_res("R5 slt 3<-1", 32'h0);
        drive(4'd5, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 16'h0, 5'd0);
        chk_res("R5 slt -2<-1", 32'h1);
        drive(4'd11, 32'hFFFF_FFF0, 32'h0, 16'hFFF8, 5'd0);
        chk_res("R5 slti -16<-8", 32'h1);
        drive(4'd11, 32'h0000_0044, 32'h0, 16'h0044, 5'd0);
        chk_res("R5 slti equal", 32'h0);
    endtask

    task automatic t_logic;     // R6
        drive(4'd2, 32'hF0F0_1234, 32'hFF00_00FF, 16'h0, 5'd0);
        chk_res("R6 and", 32'hF000_0034);
        drive(4'd3, 32'hF0F0_1234, 32'h0F00_00FF, 16'h0, 5'd0);
        chk_res("R6 or", 32'hFFF0_12FF);
        drive(4'd4, 32'hF0F0_0000, 32'h0000_000F, 16'h0, 5'd0);
        chk_res("R6 nor", 32'h0F0F_FFF0);
    endtask

    task automatic t_shift;     // R7
        drive(4'd6, 32'hB56E_47AB, 32'h0, 16'h0, 5'd16);
        chk_res("R7 sll 16", 32'h47AB_0000);
        drive(4'd7, 32'hB56E_47AB, 32'h0, 16'h0, 5'd23);
        chk_res("R7 srl 23", 32'h0000_016A);
        drive(4'd7, 32'h8000_0000, 32'h0, 16'h0, 5'd31);
        chk_res("R7 srl 31", 32'h0000_0001);
        drive(4'd6, 32'hB56E_47AB, 32'h0, 16'h0, 5'd0);
        chk_res("R7 sll 0", 32'hB56E_47AB);
    endtask

    task automatic t_eq;        // R8
        drive(4'd2, 32'hCAFE_0001, 32'hCAFE_0001, 16'h0, 5'd3);
        chk_eq("R8 equal", 1'b1);
        drive(4'd12, 32'h0000_0001, 32'h8000_0001, 16'h1, 5'd3);
        chk_eq("R8 top bit differs", 1'b0);
    endtask

    task automatic t_const_build; // R9
        logic [31:0] tmp;
        drive(4'd12, 32'h1357_9BDF, 32'h0, 16'hFAFA, 5'd0);
        tmp = result;
        drive(4'd10, tmp, 32'h0, 16'hFBFB, 5'd0);
        chk_res("R9 lui+ori", 32'hFAFA_FBFB);
    endtask

    task automatic t_unused;    // R10
        for (int c = 13; c < 16; c++) begin
            drive(4'(c), 32'hFFFF_FFFF, 32'h1234_5678, 16'hFFFF, 5'd7);
            chk_res("R10 unused code", 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add_sub();
        t_addi();
        t_logic_imm();
        t_lui();
        t_slt();
        t_logic();
        t_shift();
        t_eq();
        t_const_build();
        t_unused();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule